// File: doc/BRIEF.md
# Write-Once-Timeout Watchdog Timer

This block is a 16-bit watchdog that counts clock cycles and, when software stops servicing it, asks for a reset of the whole core and its peripherals. Software reaches it through one write-only register: a write strobe with 16 bits of data. The first nonzero value written arms the watchdog and becomes its timeout for as long as it stays armed. Any later write only restarts the countdown from that stored value. The data of such a write does not matter.

When the countdown runs out, the block raises a one-cycle reset request. It also sets a sticky flag, so that code running after the reset can tell a watchdog reset from an external one. The flag keeps its value through the reset the watchdog causes. Only power-on reset or a write of zero clears it. A write of zero never arms the watchdog. After a request the watchdog is disarmed again and no longer holds a timeout, so the next nonzero write arms it with a new value.

Top module: `wdog_once`

## Requirements
- R1: After power-on reset (`por_n` low) the watchdog is disarmed, `rst_req` and `wd_flag` are 0, and with no writes `rst_req` stays 0.
- R2: A write with nonzero data while disarmed arms the watchdog with timeout N = data. With no further writes, `rst_req` is high in the cycle after the Nth rising edge that follows the edge which sampled the write.
- R3: The timeout is 16 bits wide. Any value from 1 to 65535 (0xFFFF) gives exactly that many cycles.
- R4: Expiry sets `wd_flag` in the same cycle that `rst_req` goes high. The flag then stays set through the request and afterwards.
- R5: `rst_req` is high for exactly one cycle. After it the watchdog is disarmed, and the next nonzero write arms it with that write's value.
- R6: A write with data 0 clears `wd_flag` from the next cycle on. While disarmed it does not arm, so no `rst_req` follows.
- R7: While armed, any write restarts the countdown at the timeout latched when the watchdog was armed, whatever the write's data.
- R8: A write sampled on the edge where the countdown would expire counts as a reload: no `rst_req` is issued and the full timeout starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the watchdog counts its rising edges |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 16 | Register write data |
| rst_req | output | 1 | Reset request pulse, one cycle |
| wd_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The assertions assume `wr_en` and `wr_data` are driven to known values in every cycle once `por_n` has been released, and that `por_n` is released only after the first clock edge. The bench drives every input on the falling edge from the start, holds `por_n` low for several cycles, and after that changes `wr_data` only together with a strobe or a defined idle value. Its random phase uses short timeouts and a low write rate, so that expiry, reload at the last cycle and zero writes all occur. Directed cases cover the full 16-bit timeout and the write that collides with expiry.

// File: rtl/wdog_once.sv
module wdog_once #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rst_req,
  output logic             wd_flag
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             armed_q;
  logic [WIDTH-1:0] limit_q;
  logic [WIDTH-1:0] cnt_q;

  wire zero_wr = wr_en && (wr_data == '0);
  wire arm_wr  = wr_en && !armed_q && (wr_data != '0);
  wire reload  = wr_en && armed_q;
  wire expire  = armed_q && !wr_en && (cnt_q == ONE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed_q <= 1'b0;
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (arm_wr) begin
      armed_q <= 1'b1;
      limit_q <= wr_data;
      cnt_q   <= wr_data;
    end else if (reload) begin
      cnt_q   <= limit_q;
    end else if (expire) begin
      armed_q <= 1'b0;
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_req <= 1'b0;
    else        rst_req <= expire;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       wd_flag <= 1'b0;
    else if (expire)  wd_flag <= 1'b1;
    else if (zero_wr) wd_flag <= 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!por_n)
    !armed_q |=> !rst_req);

  assert_flag_with_req_R4: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> wd_flag);

  assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  assert_disarm_after_req_R5: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> !armed_q);

  assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data == '0) |=> !wd_flag);

  assert_limit_kept_R7: assert property (@(posedge clk) disable iff (!por_n)
    (armed_q && wr_en) |=> $stable(limit_q));

  assert_write_beats_expiry_R8: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> !rst_req);

endmodule

// File: tb/wdog_once_test.sv
module wdog_once_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic rst_req, wd_flag;

  int checks = 0;
  int failures = 0;

  bit m_armed = 0;
  bit m_flag = 0;
  bit m_req = 0;
  int m_lim = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  wdog_once uut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .rst_req(rst_req), .wd_flag(wd_flag)
  );

  function automatic bit exp_req_next(bit armed, int cnt, bit we);
    return armed && !we && cnt == 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit we, int d);
    bit nreq;
    nreq = exp_req_next(m_armed, m_cnt, we);
    if (we) begin
      if (d == 0) m_flag = 0;
      if (m_armed) m_cnt = m_lim;
      else if (d != 0) begin m_armed = 1; m_lim = d; m_cnt = d; end
    end else if (nreq) begin
      m_armed = 0; m_flag = 1; m_lim = 0; m_cnt = 0;
    end else if (m_armed) m_cnt--;
    m_req = nreq;
  endtask

  task automatic cyc(bit we, int d, string req);
    wr_en = we;
    wr_data = 16'(d);
    model_step(we, d);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 16'h0000;
    chk(req, "rst_req", int'(rst_req), int'(m_req));
    chk(req, "wd_flag", int'(wd_flag), int'(m_flag));
  endtask

  task automatic cycles_to_pulse(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rst_req && n < limit);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset rst_req", int'(rst_req), 0);
    chk("R1", "reset wd_flag", int'(wd_flag), 0);
    repeat (20) cyc(0, 0, "R1");

    cyc(1, 5, "R2");
    for (int i = 0; i < 6; i++) cyc(0, 0, "R2");
    chk("R4", "flag held after pulse", int'(wd_flag), 1);

    cyc(1, 0, "R6");
    chk("R6", "flag cleared", int'(wd_flag), 0);
    repeat (10) cyc(0, 0, "R6");

    cyc(1, 4, "R7");
    cyc(0, 0, "R7");
    cyc(0, 0, "R7");
    cyc(1, 16'hFFFF, "R7");
    for (int i = 0; i < 5; i++) cyc(0, 0, "R7");

    cyc(1, 3, "R8");
    cyc(0, 0, "R8");
    cyc(0, 0, "R8");
    cyc(1, 9, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 0, "R8");
    cyc(0, 0, "R5");
    chk("R5", "pulse width", int'(rst_req), 0);
    cyc(1, 2, "R5");
    cyc(0, 0, "R5");
    cyc(0, 0, "R5");

    wr_en = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'h0000;
    cycles_to_pulse(70000, n);
    chk("R3", "cycles for 0xFFFF", n, 65535);
    chk("R4", "flag on full timeout", int'(wd_flag), 1);
    @(negedge clk);
    chk("R5", "pulse ends", int'(rst_req), 0);
    m_armed = 0; m_flag = 1; m_req = 0; m_lim = 0; m_cnt = 0;

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 6) cyc(1, int'($urandom_range(1, 30)), "R7");
      else if (r < 8) cyc(1, 0, "R6");
      else cyc(0, 0, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule